// File: doc/BRIEF.md
# Software Interrupt Stacking Sequencer

This block carries out the software-interrupt instruction of an 8-bit processor core as a fixed nine-cycle sequence. A start strobe accepts the current program counter, accumulator, index register, condition-code register and stack pointer. The block saves a five-byte frame onto a stack that grows downward, using a byte-wide write port. It then sets the interrupt mask and builds a new program counter from a two-byte vector, which it reads over a byte-wide read port.

The program counter is advanced by one before it is stacked, so the saved return address points past the one-byte instruction. Each push writes at the current stack pointer and then decrements it. The mask bit is set only after the condition codes have been written, so the stacked copy keeps the mask value from before the interrupt. Read data from memory arrives one cycle after the read request.

Top module: `swi_seq`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0. Whenever `busy_o` is 0, neither `mem_we_o` nor `mem_re_o` is asserted.
- R2: A `start_i` sampled while `busy_o` is 0 starts a sequence. `busy_o` is then high for exactly 9 cycles, numbered 0 to 8. A `start_i` sampled while `busy_o` is 1 is ignored.
- R3: Cycles 1 to 5 are writes. The addresses are SP, SP-1, SP-2, SP-3 and SP-4, where SP is `sp_i` at start. The data bytes, in order, are PC[7:0], PC[15:8], X, A and CCR, where PC is `pc_i`+1 modulo 2^16.
- R4: At the end of the sequence, `sp_o` equals `sp_i`-5 modulo 2^16, and SP decreases by one after each write.
- R5: The CCR byte that is stacked is `ccr_i` unchanged. The final `ccr_o` is `ccr_i` with bit 3 (the interrupt mask) set to 1, and every other bit is unchanged.
- R6: Cycle 6 reads address 0xFFFC (the vector high byte) and cycle 7 reads address 0xFFFD (the vector low byte). Each data byte is sampled one cycle after its request. The final `pc_o` is {high, low}.
- R7: At most one memory access takes place per cycle. Cycles 0 and 8 make no access.
- R8: `done_o` is a single-cycle pulse in the cycle after cycle 8, with `busy_o` 0. A `start_i` in that same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for one instruction |
| pc_i | input | 16 | Program counter of the instruction |
| a_i | input | 8 | Accumulator |
| x_i | input | 8 | Index register |
| ccr_i | input | 8 | Condition-code register |
| sp_i | input | 16 | Stack pointer |
| mem_addr_o | output | 16 | Memory address |
| mem_we_o | output | 1 | Write request |
| mem_wdata_o | output | 8 | Write data |
| mem_re_o | output | 1 | Read request |
| mem_rdata_i | input | 8 | Read data, one cycle after the request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed (one-cycle pulse) |
| sp_o | output | 16 | Working and final stack pointer |
| ccr_o | output | 8 | Working and final condition codes |
| pc_o | output | 16 | Working and final program counter |

## Verification
The completion pulse of one instruction and the acceptance of the next start strobe can fall in the same cycle. The bench provokes this by running its vector table back to back: each new start is driven in the cycle where `done_o` of the previous run is high. It then judges the new run by its full frame of addresses, data bytes and final registers, which are built from the freshly presented inputs. A second overlap is a start strobe driven in the middle of a run. The bench judges it by checking that the run still ends after nine busy cycles, with no extra access and no retrigger.

// File: rtl/swi_seq_pkg.sv
`timescale 1ns/1ps
package swi_seq_pkg;
  localparam int STEP_W = 4;
  localparam logic [STEP_W-1:0] STEP_LOAD  = 4'd0;
  localparam logic [STEP_W-1:0] STEP_PCL   = 4'd1;
  localparam logic [STEP_W-1:0] STEP_PCH   = 4'd2;
  localparam logic [STEP_W-1:0] STEP_X     = 4'd3;
  localparam logic [STEP_W-1:0] STEP_A     = 4'd4;
  localparam logic [STEP_W-1:0] STEP_CCR   = 4'd5;
  localparam logic [STEP_W-1:0] STEP_VHI   = 4'd6;
  localparam logic [STEP_W-1:0] STEP_VLO   = 4'd7;
  localparam logic [STEP_W-1:0] STEP_LAST  = 4'd8;
  localparam int SEQ_CYCLES = int'(STEP_LAST) + 1;

  function automatic logic is_push(input logic [STEP_W-1:0] s);
    return (s >= STEP_PCL) && (s <= STEP_CCR);
  endfunction
endpackage

// File: rtl/swi_seq_ctrl.sv
`timescale 1ns/1ps
module swi_seq_ctrl
  import swi_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              load_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [STEP_W-1:0] step_o
);
  logic              busy_q, done_q;
  logic [STEP_W-1:0] step_q;

  assign load_o = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= STEP_LOAD;
    end else begin
      done_q <= busy_q && (step_q == STEP_LAST);
      if (load_o) begin
        busy_q <= 1'b1;
        step_q <= STEP_LOAD;
      end else if (busy_q) begin
        if (step_q == STEP_LAST) begin
          busy_q <= 1'b0;
          step_q <= STEP_LOAD;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign step_o = step_q;
endmodule

// File: rtl/swi_seq_regs.sv
`timescale 1ns/1ps
module swi_seq_regs
  import swi_seq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int I_BIT = 3,
  localparam int AW   = 2 * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              busy_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     x_i,
  input  logic [DW-1:0]     ccr_i,
  input  logic [AW-1:0]     sp_i,
  input  logic [DW-1:0]     rdata_i,
  output logic [AW-1:0]     pc_o,
  output logic [DW-1:0]     a_o,
  output logic [DW-1:0]     x_o,
  output logic [DW-1:0]     ccr_o,
  output logic [AW-1:0]     sp_o
);
  logic [AW-1:0] pc_q, sp_q;
  logic [DW-1:0] a_q, x_q, ccr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      sp_q  <= '0;
      a_q   <= '0;
      x_q   <= '0;
      ccr_q <= '0;
    end else if (load_i) begin
      pc_q  <= pc_i + AW'(1);
      sp_q  <= sp_i;
      a_q   <= a_i;
      x_q   <= x_i;
      ccr_q <= ccr_i;
    end else if (busy_i) begin
      if (is_push(step_i)) sp_q <= sp_q - AW'(1);
      // mask set only once the CCR byte has gone out
      if (step_i == STEP_CCR) ccr_q[I_BIT] <= 1'b1;
      if (step_i == STEP_VLO) pc_q[AW-1:DW] <= rdata_i;
      if (step_i == STEP_LAST) pc_q[DW-1:0] <= rdata_i;
    end
  end

  assign pc_o  = pc_q;
  assign sp_o  = sp_q;
  assign a_o   = a_q;
  assign x_o   = x_q;
  assign ccr_o = ccr_q;
endmodule

// File: rtl/swi_seq_mem.sv
`timescale 1ns/1ps
module swi_seq_mem
  import swi_seq_pkg::*;
#(
  parameter int DW             = 8,
  localparam int AW            = 2 * DW,
  parameter logic [AW-1:0] VEC_BASE = 16'hFFFC
) (
  input  logic              busy_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     x_i,
  input  logic [DW-1:0]     ccr_i,
  input  logic [AW-1:0]     sp_i,
  output logic [AW-1:0]     addr_o,
  output logic              we_o,
  output logic [DW-1:0]     wdata_o,
  output logic              re_o
);
  always_comb begin
    we_o    = 1'b0;
    re_o    = 1'b0;
    addr_o  = sp_i;
    wdata_o = '0;
    if (busy_i) begin
      unique case (step_i)
        STEP_PCL: begin we_o = 1'b1; wdata_o = pc_i[DW-1:0];  end
        STEP_PCH: begin we_o = 1'b1; wdata_o = pc_i[AW-1:DW]; end
        STEP_X:   begin we_o = 1'b1; wdata_o = x_i;           end
        STEP_A:   begin we_o = 1'b1; wdata_o = a_i;           end
        STEP_CCR: begin we_o = 1'b1; wdata_o = ccr_i;         end
        STEP_VHI: begin re_o = 1'b1; addr_o = VEC_BASE;              end
        STEP_VLO: begin re_o = 1'b1; addr_o = VEC_BASE + AW'(1);     end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/swi_seq.sv
`timescale 1ns/1ps
module swi_seq
  import swi_seq_pkg::*;
#(
  parameter int DW                  = 8,
  parameter int I_BIT               = 3,
  localparam int AW                 = 2 * DW,
  parameter logic [AW-1:0] VEC_BASE = 16'hFFFC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] ccr_i,
  input  logic [AW-1:0] sp_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_re_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] sp_o,
  output logic [DW-1:0] ccr_o,
  output logic [AW-1:0] pc_o
);
  logic              load;
  logic [STEP_W-1:0] step;
  logic [DW-1:0]     a_w, x_w;

  swi_seq_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .step_o  (step)
  );

  swi_seq_regs #(.DW(DW), .I_BIT(I_BIT)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .busy_i  (busy_o),
    .step_i  (step),
    .pc_i    (pc_i),
    .a_i     (a_i),
    .x_i     (x_i),
    .ccr_i   (ccr_i),
    .sp_i    (sp_i),
    .rdata_i (mem_rdata_i),
    .pc_o    (pc_o),
    .a_o     (a_w),
    .x_o     (x_w),
    .ccr_o   (ccr_o),
    .sp_o    (sp_o)
  );

  swi_seq_mem #(.DW(DW), .VEC_BASE(VEC_BASE)) u_mem (
    .busy_i  (busy_o),
    .step_i  (step),
    .pc_i    (pc_o),
    .a_i     (a_w),
    .x_i     (x_w),
    .ccr_i   (ccr_o),
    .sp_i    (sp_o),
    .addr_o  (mem_addr_o),
    .we_o    (mem_we_o),
    .wdata_o (mem_wdata_o),
    .re_o    (mem_re_o)
  );
endmodule

// File: rtl/swi_seq_chk.sv
`timescale 1ns/1ps
module swi_seq_chk
  import swi_seq_pkg::*;
#(
  parameter int DW                  = 8,
  parameter int I_BIT               = 3,
  localparam int AW                 = 2 * DW,
  parameter logic [AW-1:0] VEC_BASE = 16'hFFFC
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic          busy_o,
  input logic          done_o,
  input logic [AW-1:0] sp_o,
  input logic [DW-1:0] ccr_o
);
  logic [STEP_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (busy_o)  run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_we_o && !mem_re_o));
  p_busy_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(run_q) == SEQ_CYCLES));
  p_start_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
  p_sp_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (sp_o == $past(sp_o) - AW'(1)));
  p_mask_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ccr_o[I_BIT]);
  p_vec_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> (mem_addr_o[AW-1:1] == VEC_BASE[AW-1:1]));
  p_one_access_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind swi_seq swi_seq_chk #(.DW(DW), .I_BIT(I_BIT), .VEC_BASE(VEC_BASE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mem_addr_o (mem_addr_o),
  .mem_we_o   (mem_we_o),
  .mem_re_o   (mem_re_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .sp_o       (sp_o),
  .ccr_o      (ccr_o)
);

// File: tb/swi_seq_tb.sv
`timescale 1ns/1ps
module swi_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] pc_i = '0, sp_i = '0;
  logic [7:0]  a_i = '0, x_i = '0, ccr_i = '0;
  logic [15:0] mem_addr_o;
  logic        mem_we_o, mem_re_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        busy_o, done_o;
  logic [15:0] sp_o, pc_o;
  logic [7:0]  ccr_o;
  logic [7:0]  vec_hi = '0, vec_lo = '0;
  int total = 0, bad = 0;

  always #10 clk_i = ~clk_i;

  swi_seq u_dut (.*);

  // vector memory model, one-cycle read latency
  always_ff @(posedge clk_i) begin
    if (mem_re_o)
      mem_rdata_i <= (mem_addr_o == 16'hFFFC) ? vec_hi :
                     (mem_addr_o == 16'hFFFD) ? vec_lo : 8'h00;
  end

  // pc, a, x, ccr, sp, vector high, vector low
  localparam int NV = 5;
  localparam logic [71:0] TBL [NV] = '{
    {16'h1234, 8'hA5, 8'h3C, 8'h60, 16'h00FF, 8'h80, 8'h10},
    {16'hFFFF, 8'h01, 8'h02, 8'h6F, 16'h0002, 8'hE0, 8'h00},
    {16'h00FE, 8'hFF, 8'h00, 8'h68, 16'h1000, 8'h12, 8'hFF},
    {16'h7F00, 8'h5A, 8'hC3, 8'hE7, 16'h0005, 8'h00, 8'h01},
    {16'hABCD, 8'h00, 8'hFF, 8'h00, 16'hFFFF, 8'hFF, 8'hFE}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive at a negedge with busy_o low; returns at the negedge where done_o is high
  task automatic run_swi(input logic [71:0] t, input bit inject);
    logic [15:0] pc1, sp0;
    logic [7:0]  ea, ex, ec;
    pc1 = t[71:56] + 16'd1;
    ea = t[55:48]; ex = t[47:40]; ec = t[39:32]; sp0 = t[31:16];
    pc_i = t[71:56]; a_i = ea; x_i = ex; ccr_i = ec; sp_i = sp0;
    vec_hi = t[15:8]; vec_lo = t[7:0];
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R2 busy at cycle 0", {31'd0, busy_o}, 32'd1);
    chk("R7 no access cycle 0", {30'd0, mem_we_o, mem_re_o}, 32'd0);
    for (int k = 1; k <= 8; k++) begin
      if (inject && k == 3) start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      chk("R2 busy held", {31'd0, busy_o}, 32'd1);
      if (k <= 5) begin
        logic [7:0] d;
        case (k)
          1: d = pc1[7:0];
          2: d = pc1[15:8];
          3: d = ex;
          4: d = ea;
          default: d = ec;
        endcase
        chk("R3 write strobe", {30'd0, mem_we_o, mem_re_o}, 32'd2);
        chk("R3 push address", {16'd0, mem_addr_o}, {16'd0, sp0 - 16'(k - 1)});
        chk(k == 5 ? "R5 stacked ccr" : "R3 push data", {24'd0, mem_wdata_o}, {24'd0, d});
      end else if (k <= 7) begin
        chk("R6 read strobe", {30'd0, mem_we_o, mem_re_o}, 32'd1);
        chk("R6 vector address", {16'd0, mem_addr_o}, (k == 6) ? 32'hFFFC : 32'hFFFD);
      end else begin
        chk("R7 no access cycle 8", {30'd0, mem_we_o, mem_re_o}, 32'd0);
      end
    end
    @(negedge clk_i);
    chk("R8 done with busy low", {30'd0, busy_o, done_o}, 32'd1);
    chk("R4 final sp", {16'd0, sp_o}, {16'd0, sp0 - 16'd5});
    chk("R5 final ccr", {24'd0, ccr_o}, {24'd0, ec | 8'h08});
    chk("R6 final pc", {16'd0, pc_o}, {16'd0, t[15:8], t[7:0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    start_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1 reset busy/done", {30'd0, busy_o, done_o}, 32'd0);
    chk("R1 reset no access", {30'd0, mem_we_o, mem_re_o}, 32'd0);
    start_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle after reset", {28'd0, busy_o, done_o, mem_we_o, mem_re_o}, 32'd0);

    // table walked back to back: each start lands in the previous done cycle (R8)
    for (int i = 0; i < NV; i++) run_swi(TBL[i], 1'b0);
    @(negedge clk_i);
    chk("R8 done single pulse", {30'd0, busy_o, done_o}, 32'd0);

    // start strobe mid-run is ignored (R2)
    repeat (2) @(negedge clk_i);
    run_swi({16'h4000, 8'h11, 8'h22, 8'h00, 16'h0200, 8'h90, 8'h00}, 1'b1);
    @(negedge clk_i);
    chk("R2 no retrigger", {28'd0, busy_o, done_o, mem_we_o, mem_re_o}, 32'd0);
    repeat (3) @(negedge clk_i);
    chk("R1 stays idle", {28'd0, busy_o, done_o, mem_we_o, mem_re_o}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule